// File: doc/BRIEF.md
# Three-Port Parallel Interface with Bit Set/Reset

This block is a host-programmed parallel I/O peripheral with three 8-bit ports, called A, B and C. The host reaches them through a chip select, two address bits and separate read and write strobes. A write-only control register takes two kinds of word, and bit 7 tells them apart. One kind sets the port directions and the group modes. The other sets or clears a single port C bit. Port A and the upper half of port C form group A. Port B and the lower half of port C form group B.

In simple I/O mode, each port or half-port is an input or an output. Outputs come from a latch, and inputs are read straight from the pins. In strobed mode, the 8-bit port of a group is latched in both directions. Some port C pins then take on handshake roles: strobe or acknowledge inputs, and buffer-full and interrupt outputs. Group A also has a bidirectional mode. In that mode port A drives its pins only while the device acknowledges. Port C bits 3 to 7 then carry the handshakes for both directions.

Pins are modelled as separate input, output and output-enable vectors. All handshake inputs are sampled on the block clock.

Top module: `pio3_port`

## Requirements
- R1: After reset, all ports are in simple mode and set to input: pa_oe_o = 0, pb_oe_o = 0, pc_oe_o = 0x00. A read of port A returns pa_i.
- R2: With cs_ni low, addr_i selects the target: 0 is port A, 1 is port B, 2 is port C and 3 is the control register. A write with cs_ni high changes nothing.
- R3: A control write with bit 7 = 1 is a mode word. Bits 6:5 give the group A mode (00 simple, 01 strobed, 1x bidirectional). Bit 4 is the port A direction. Bit 3 is the port C bits 7:4 direction. Bit 2 is the group B mode (0 simple, 1 strobed). Bit 1 is the port B direction. Bit 0 is the port C bits 3:0 direction. A direction bit of 1 means input. A mode word also clears every output latch and every handshake flag.
- R4: A control write with bit 7 = 0 sets port C bit number wdata[3:1] to wdata[0]. Bits 6:4 are ignored. Modes, directions and the port A and B latches stay unchanged.
- R5: In simple mode, an output port drives its latched value. A read of an input port returns its pins.
- R6: In group A strobed input mode (the mode word has bits 6:5 = 01 and bit 4 = 1):
  - PC4 is the active-low strobe input, PC5 is the buffer-full output and PC3 is the interrupt output.
  - A falling edge on PC4 latches pa_i and sets buffer-full.
  - A rising edge on PC4 while buffer-full is set raises the interrupt, provided port C latch bit 4 (the enable) is 1.
  - A read of port A returns the latched byte and clears buffer-full and the interrupt.
- R7: In group A strobed output mode, PC7 is the active-low output-buffer-full pin and PC6 is the active-low acknowledge. A host write to port A drives PC7 low and clears the interrupt on PC3. A falling edge on PC6 returns PC7 high and raises PC3 if port C latch bit 6 is 1.
- R8: In group B strobed mode, PC2 is the strobe or the acknowledge, PC1 is the buffer-full pin and PC0 is the interrupt. PC1 is high when the input buffer is full and low when the output buffer is full. Port C latch bit 2 is the interrupt enable. The events and clears follow R6 and R7, applied to port B.
- R9: In group A bidirectional mode, port A drives its pins only while PC6 is low. PC7, PC6, PC5, PC4 and PC3 keep their R6 and R7 roles. The interrupt on PC3 is raised by either direction.
- R10: In a strobed or bidirectional mode, a port C write changes only the bits that have no handshake role. A port C read returns:
  - the status value at each handshake output bit;
  - the enable latch bit at each strobe or acknowledge bit;
  - the pins at other input bits;
  - the latch at other output bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| addr_i | input | 2 | Register select |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational; 0 when deselected or when addressing the control register |
| pa_i | input | 8 | Port A pin levels |
| pa_o | output | 8 | Port A drive value |
| pa_oe_o | output | 1 | Port A output enable |
| pb_i | input | 8 | Port B pin levels |
| pb_o | output | 8 | Port B drive value |
| pb_oe_o | output | 1 | Port B output enable |
| pc_i | input | 8 | Port C pin levels |
| pc_o | output | 8 | Port C drive values |
| pc_oe_o | output | 8 | Port C per-bit output enables |

## Verification
The bench follows the shared control address from both sides. A bit set/reset word that leaked into the mode register would turn outputs into inputs and wipe the port A latch. A mode word that failed to clear would leave a stale byte on port A after reprogramming. It drives the strobe and acknowledge pins through full edge sequences with the enables set by bit set/reset words. A design that used the wrong edge, skipped the enable or failed to clear on a host access would show a wrong PC1, PC3, PC5 or PC7 level in the following cycle. In bidirectional mode it checks that port A is released as soon as the acknowledge rises, which a design holding the bus would fail. It also checks that port C writes in a handshake mode leave the enable bits intact.

// File: rtl/pio3_pkg.sv
package pio3_pkg;
  localparam int unsigned DW = 8;

  // field order matches bits 6:0 of a mode word
  typedef struct packed {
    logic [1:0] a_mode;
    logic       a_in;
    logic       cu_in;
    logic       b_mode;
    logic       b_in;
    logic       cl_in;
  } cfg_t;

  localparam cfg_t CFG_RST = '{a_mode: 2'b00, a_in: 1'b1, cu_in: 1'b1,
                               b_mode: 1'b0, b_in: 1'b1, cl_in: 1'b1};

  localparam logic [1:0] SEL_A   = 2'd0;
  localparam logic [1:0] SEL_B   = 2'd1;
  localparam logic [1:0] SEL_C   = 2'd2;
  localparam logic [1:0] SEL_CTL = 2'd3;

  localparam int unsigned PC_A_INTR = 3;
  localparam int unsigned PC_A_STB  = 4;
  localparam int unsigned PC_A_IBF  = 5;
  localparam int unsigned PC_A_ACK  = 6;
  localparam int unsigned PC_A_OBF  = 7;
  localparam int unsigned PC_B_INTR = 0;
  localparam int unsigned PC_B_BF   = 1;
  localparam int unsigned PC_B_HS   = 2;
endpackage

// File: rtl/pio3_ctrl.sv
module pio3_ctrl
  import pio3_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ctl_wr_i,
  input  logic         pc_wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] hs_mask_i,
  output cfg_t         cfg_o,
  output logic         cfg_load_o,
  output logic [W-1:0] pc_lat_o
);
  localparam int unsigned SELW = $clog2(W);

  assign cfg_load_o = ctl_wr_i & wdata_i[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o    <= CFG_RST;
      pc_lat_o <= '0;
    end else if (cfg_load_o) begin
      cfg_o    <= cfg_t'(wdata_i[$bits(cfg_t)-1:0]);
      pc_lat_o <= '0;
    end else if (ctl_wr_i) begin
      pc_lat_o[wdata_i[SELW:1]] <= wdata_i[0];
    end else if (pc_wr_i) begin
      pc_lat_o <= (pc_lat_o & hs_mask_i) | (wdata_i & ~hs_mask_i);
    end
  end

  // R4
  bsr_keeps_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && !wdata_i[W-1]) |=> (cfg_o == $past(cfg_o)));
endmodule

// File: rtl/pio3_hs.sv
module pio3_hs #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         in_en_i,
  input  logic         out_en_i,
  input  logic         host_wr_i,
  input  logic         host_rd_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] port_i,
  input  logic         stb_ni,
  input  logic         ack_ni,
  input  logic         inte_in_i,
  input  logic         inte_out_i,
  output logic [W-1:0] out_lat_o,
  output logic [W-1:0] in_lat_o,
  output logic         ibf_o,
  output logic         obf_o,
  output logic         intr_o
);
  logic stb_q, ack_q;
  logic stb_fall, stb_rise, ack_fall;

  assign stb_fall = stb_q & ~stb_ni;
  assign stb_rise = ~stb_q & stb_ni;
  assign ack_fall = ack_q & ~ack_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q     <= 1'b1;
      ack_q     <= 1'b1;
      out_lat_o <= '0;
      in_lat_o  <= '0;
      ibf_o     <= 1'b0;
      obf_o     <= 1'b0;
      intr_o    <= 1'b0;
    end else begin
      stb_q <= stb_ni;
      ack_q <= ack_ni;
      if (clr_i) begin
        out_lat_o <= '0;
        in_lat_o  <= '0;
        ibf_o     <= 1'b0;
        obf_o     <= 1'b0;
        intr_o    <= 1'b0;
      end else begin
        // host clears first, pin events override
        if (host_wr_i) out_lat_o <= wdata_i;
        if (host_wr_i && out_en_i) begin
          obf_o  <= 1'b1;
          intr_o <= 1'b0;
        end
        if (host_rd_i && in_en_i) begin
          ibf_o  <= 1'b0;
          intr_o <= 1'b0;
        end
        if (in_en_i && stb_fall) begin
          in_lat_o <= port_i;
          ibf_o    <= 1'b1;
        end
        if (in_en_i && stb_rise && ibf_o && inte_in_i) intr_o <= 1'b1;
        if (out_en_i && ack_fall) begin
          obf_o <= 1'b0;
          if (inte_out_i) intr_o <= 1'b1;
        end
      end
    end
  end

  // R3
  mode_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (out_lat_o == '0 && !ibf_o && !obf_o && !intr_o));
  // R7
  obf_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && out_en_i && !clr_i && !(ack_q && !ack_ni)) |=> obf_o);
  // R6
  strobe_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_en_i && stb_q && !stb_ni && !clr_i) |=> (ibf_o && in_lat_o == $past(port_i)));
endmodule

// File: rtl/pio3_port.sv
module pio3_port
  import pio3_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cs_ni,
  input  logic [1:0]   addr_i,
  input  logic         wr_i,
  input  logic         rd_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic [W-1:0] pa_i,
  output logic [W-1:0] pa_o,
  output logic         pa_oe_o,
  input  logic [W-1:0] pb_i,
  output logic [W-1:0] pb_o,
  output logic         pb_oe_o,
  input  logic [W-1:0] pc_i,
  output logic [W-1:0] pc_o,
  output logic [W-1:0] pc_oe_o
);
  localparam int unsigned HALF = W / 2;

  logic         acc, wr_a, wr_b, wr_c, wr_ctl, rd_a, rd_b;
  cfg_t         cfg;
  logic         cfg_load;
  logic [W-1:0] pc_lat, hs_out, hs_in, hs_mask, st, dir_out;
  logic         a_m1, a_m2, a_in_en, a_out_en, b_in_en, b_out_en;
  logic [W-1:0] a_out_lat, a_in_lat, b_out_lat, b_in_lat;
  logic         a_ibf, a_obf, a_intr, b_ibf, b_obf, b_intr;

  assign acc    = ~cs_ni;
  assign wr_a   = acc & wr_i & (addr_i == SEL_A);
  assign wr_b   = acc & wr_i & (addr_i == SEL_B);
  assign wr_c   = acc & wr_i & (addr_i == SEL_C);
  assign wr_ctl = acc & wr_i & (addr_i == SEL_CTL);
  assign rd_a   = acc & rd_i & (addr_i == SEL_A);
  assign rd_b   = acc & rd_i & (addr_i == SEL_B);

  assign a_m1     = (cfg.a_mode == 2'b01);
  assign a_m2     = cfg.a_mode[1];
  assign a_in_en  = (a_m1 & cfg.a_in) | a_m2;
  assign a_out_en = (a_m1 & ~cfg.a_in) | a_m2;
  assign b_in_en  = cfg.b_mode & cfg.b_in;
  assign b_out_en = cfg.b_mode & ~cfg.b_in;

  pio3_ctrl #(.W(W)) u_ctrl (
    .clk_i, .rst_ni,
    .ctl_wr_i (wr_ctl),
    .pc_wr_i  (wr_c),
    .wdata_i,
    .hs_mask_i(hs_mask),
    .cfg_o    (cfg),
    .cfg_load_o(cfg_load),
    .pc_lat_o (pc_lat)
  );

  pio3_hs #(.W(W)) u_hs_a (
    .clk_i, .rst_ni,
    .clr_i     (cfg_load),
    .in_en_i   (a_in_en),
    .out_en_i  (a_out_en),
    .host_wr_i (wr_a),
    .host_rd_i (rd_a),
    .wdata_i,
    .port_i    (pa_i),
    .stb_ni    (pc_i[PC_A_STB]),
    .ack_ni    (pc_i[PC_A_ACK]),
    .inte_in_i (pc_lat[PC_A_STB]),
    .inte_out_i(pc_lat[PC_A_ACK]),
    .out_lat_o (a_out_lat),
    .in_lat_o  (a_in_lat),
    .ibf_o     (a_ibf),
    .obf_o     (a_obf),
    .intr_o    (a_intr)
  );

  pio3_hs #(.W(W)) u_hs_b (
    .clk_i, .rst_ni,
    .clr_i     (cfg_load),
    .in_en_i   (b_in_en),
    .out_en_i  (b_out_en),
    .host_wr_i (wr_b),
    .host_rd_i (rd_b),
    .wdata_i,
    .port_i    (pb_i),
    .stb_ni    (pc_i[PC_B_HS]),
    .ack_ni    (pc_i[PC_B_HS]),
    .inte_in_i (pc_lat[PC_B_HS]),
    .inte_out_i(pc_lat[PC_B_HS]),
    .out_lat_o (b_out_lat),
    .in_lat_o  (b_in_lat),
    .ibf_o     (b_ibf),
    .obf_o     (b_obf),
    .intr_o    (b_intr)
  );

  // port C pin roles
  always_comb begin
    hs_out = '0;
    hs_in  = '0;
    st     = '0;
    if (a_in_en) begin
      hs_out[PC_A_INTR] = 1'b1;
      hs_out[PC_A_IBF]  = 1'b1;
      hs_in[PC_A_STB]   = 1'b1;
    end
    if (a_out_en) begin
      hs_out[PC_A_INTR] = 1'b1;
      hs_out[PC_A_OBF]  = 1'b1;
      hs_in[PC_A_ACK]   = 1'b1;
    end
    if (cfg.b_mode) begin
      hs_out[PC_B_INTR] = 1'b1;
      hs_out[PC_B_BF]   = 1'b1;
      hs_in[PC_B_HS]    = 1'b1;
    end
    st[PC_A_INTR] = a_intr;
    st[PC_A_IBF]  = a_ibf;
    st[PC_A_OBF]  = ~a_obf;
    st[PC_B_INTR] = b_intr;
    st[PC_B_BF]   = cfg.b_in ? b_ibf : ~b_obf;
  end

  for (genvar i = 0; i < W; i++) begin : g_dir
    if (i < HALF) begin : g_lo
      assign dir_out[i] = ~cfg.cl_in;
    end else begin : g_hi
      assign dir_out[i] = ~cfg.cu_in;
    end
  end

  assign hs_mask = hs_out | hs_in;
  assign pc_oe_o = (dir_out & ~hs_mask) | hs_out;
  assign pc_o    = (pc_lat & ~hs_out) | (st & hs_out);
  assign pa_o    = a_out_lat;
  assign pb_o    = b_out_lat;
  assign pa_oe_o = a_m2 ? ~pc_i[PC_A_ACK] : ~cfg.a_in;
  assign pb_oe_o = ~cfg.b_in;

  always_comb begin
    rdata_o = '0;
    if (acc) begin
      unique case (addr_i)
        SEL_A:   rdata_o = a_in_en ? a_in_lat : (cfg.a_in ? pa_i : a_out_lat);
        SEL_B:   rdata_o = b_in_en ? b_in_lat : (cfg.b_in ? pb_i : b_out_lat);
        SEL_C:   rdata_o = (st & hs_out) | (pc_lat & hs_in)
                         | (pc_i & ~hs_mask & ~dir_out) | (pc_lat & ~hs_mask & dir_out);
        default: rdata_o = '0;
      endcase
    end
  end

  // R2
  deselect_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (pa_o == $past(pa_o) && pb_o == $past(pb_o)));
  // R5
  simple_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_a && cfg.a_mode == 2'b00) |=> (pa_o == $past(wdata_i)));
  // R9
  bidir_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_m2 && pc_i[PC_A_ACK]) |-> !pa_oe_o);
  // R7
  obf_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_a && a_out_en && !cfg_load && pc_i[PC_A_ACK]) |=> !pc_o[PC_A_OBF]);
endmodule

// File: tb/sim_pio3_port.sv
module sim_pio3_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic [7:0] pa_i = '0, pb_i = '0, pc_i = 8'hFF;
  logic [7:0] pa_o, pb_o, pc_o, pc_oe;
  logic       pa_oe, pb_oe;

  always #2 clk = ~clk;

  pio3_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata),
    .pa_i(pa_i), .pa_o(pa_o), .pa_oe_o(pa_oe),
    .pb_i(pb_i), .pb_o(pb_o), .pb_oe_o(pb_oe),
    .pc_i(pc_i), .pc_o(pc_o), .pc_oe_o(pc_oe)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  string cur_req = "R1";
  logic [7:0] last_rd;

  // reference model state
  int   m_am = 0;
  bit   m_ain = 1, m_cuin = 1, m_bm = 0, m_bin = 1, m_clin = 1;
  logic [7:0] m_pa = 0, m_pb = 0, m_pc = 0, m_prev = 8'hFF;
  bit   ibf_a = 0, obf_a = 0, intr_a = 0, ibf_b = 0, obf_b = 0, intr_b = 0;

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit ain_r();  return (m_am == 1 && m_ain) || m_am >= 2; endfunction
  function automatic bit aout_r(); return (m_am == 1 && !m_ain) || m_am >= 2; endfunction

  function automatic logic [7:0] exp_hsout();
    logic [7:0] v = 0;
    if (ain_r())  v |= 8'h28;
    if (aout_r()) v |= 8'h88;
    if (m_bm)     v |= 8'h03;
    return v;
  endfunction

  function automatic logic [7:0] exp_hsin();
    logic [7:0] v = 0;
    if (ain_r())  v |= 8'h10;
    if (aout_r()) v |= 8'h40;
    if (m_bm)     v |= 8'h04;
    return v;
  endfunction

  function automatic logic [7:0] exp_pc_oe();
    logic [7:0] v = {{4{!m_cuin}}, {4{!m_clin}}};
    v = v & ~(exp_hsout() | exp_hsin());
    return v | exp_hsout();
  endfunction

  function automatic logic [7:0] exp_pc_o();
    logic [7:0] v = m_pc;
    if (ain_r())  begin v[3] = intr_a; v[5] = ibf_a; end
    if (aout_r()) begin v[3] = intr_a; v[7] = !obf_a; end
    if (m_bm)     begin v[0] = intr_b; v[1] = m_bin ? ibf_b : !obf_b; end
    return v;
  endfunction

  task automatic model_upd(input bit cs, input logic [1:0] a, input bit w, input bit r, input logic [7:0] d);
    bit acc = !cs;
    bit ai = ain_r(), ao = aout_r();
    bit bi = m_bm && m_bin, bo = m_bm && !m_bin;
    logic [7:0] hm = exp_hsout() | exp_hsin();
    if (acc && w && a == 3 && d[7]) begin
      m_am = int'(d[6:5]); m_ain = d[4]; m_cuin = d[3]; m_bm = d[2]; m_bin = d[1]; m_clin = d[0];
      m_pa = 0; m_pb = 0; m_pc = 0;
      ibf_a = 0; obf_a = 0; intr_a = 0; ibf_b = 0; obf_b = 0; intr_b = 0;
    end else begin
      if (acc && w) begin
        case (a)
          0: begin m_pa = d; if (ao) begin obf_a = 1; intr_a = 0; end end
          1: begin m_pb = d; if (bo) begin obf_b = 1; intr_b = 0; end end
          2: m_pc = (m_pc & hm) | (d & ~hm);
          default: m_pc[d[3:1]] = d[0];
        endcase
      end
      if (acc && r && a == 0 && ai) begin ibf_a = 0; intr_a = 0; end
      if (acc && r && a == 1 && bi) begin ibf_b = 0; intr_b = 0; end
      if (ai && m_prev[4] && !pc_i[4]) ibf_a = 1;
      if (ai && !m_prev[4] && pc_i[4] && ibf_a && m_pc[4]) intr_a = 1;
      if (ao && m_prev[6] && !pc_i[6]) begin obf_a = 0; if (m_pc[6]) intr_a = 1; end
      if (bi && m_prev[2] && !pc_i[2]) ibf_b = 1;
      if (bi && !m_prev[2] && pc_i[2] && ibf_b && m_pc[2]) intr_b = 1;
      if (bo && m_prev[2] && !pc_i[2]) begin obf_b = 0; if (m_pc[2]) intr_b = 1; end
    end
    m_prev = pc_i;
  endtask

  task automatic compare_all();
    logic [7:0] oe = exp_pc_oe();
    bit e_pa_oe = (m_am >= 2) ? !pc_i[6] : !m_ain;
    chk(cur_req, {7'd0, pa_oe, pa_o, 7'd0, pb_oe, pb_o, pc_oe, pc_o & pc_oe},
        {7'd0, e_pa_oe, m_pa, 7'd0, !m_bin, m_pb, oe, exp_pc_o() & oe}, "pins");
  endtask

  task automatic cyc(input bit cs, input logic [1:0] a, input bit w, input bit r, input logic [7:0] d);
    cs_n = cs; addr = a; wr = w; rd = r; wdata = d;
    #1 last_rd = rdata;
    @(posedge clk);
    model_upd(cs, a, w, r, d);
    @(negedge clk);
    compare_all();
    cs_n = 1'b1; wr = 1'b0; rd = 1'b0;
  endtask

  task automatic idle();              cyc(1, 0, 0, 0, 8'h00); endtask
  task automatic wreg(input logic [1:0] a, input logic [7:0] d); cyc(0, a, 1, 0, d); endtask
  task automatic rreg(input logic [1:0] a); cyc(0, a, 0, 1, 8'h00); endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    cur_req = "R1";
    chk("R1", {40'd0, pa_oe, pb_oe, 6'd0}, 48'd0, "oe after reset");
    chk("R1", {40'd0, pc_oe}, 48'd0, "pc_oe after reset");
    pa_i = 8'h5A;
    rreg(0);
    chk("R1", {40'd0, last_rd}, {40'd0, 8'h5A}, "port A input read");

    // R3/R5 simple outputs
    cur_req = "R5";
    wreg(3, 8'h80);
    wreg(0, 8'h3C); wreg(1, 8'hC3); wreg(2, 8'h96);
    chk("R5", {40'd0, pc_o}, {40'd0, 8'h96}, "port C out");
    chk("R5", {40'd0, pc_oe}, {40'd0, 8'hFF}, "port C oe");
    rreg(0);
    chk("R5", {40'd0, last_rd}, {40'd0, 8'h3C}, "port A latch read");

    // R2 deselected writes
    cur_req = "R2";
    cyc(1, 0, 1, 0, 8'hFF);
    cyc(1, 3, 1, 0, 8'h9B);
    chk("R2", {40'd0, pa_o}, {40'd0, 8'h3C}, "port A kept");
    chk("R2", {47'd0, pa_oe}, 48'd1, "mode kept");

    // R4 bit set/reset
    cur_req = "R4";
    wreg(3, 8'h0E);
    chk("R4", {40'd0, pc_o}, {40'd0, 8'h16}, "clear PC7");
    wreg(3, 8'h77);
    chk("R4", {40'd0, pc_o}, {40'd0, 8'h1E}, "set PC3 with bits 6:4 set");
    chk("R4", {39'd0, pa_oe, pa_o}, {39'd0, 1'b1, 8'h3C}, "mode and latch unchanged");

    // R3 mode word fields and clearing
    cur_req = "R3";
    wreg(3, 8'h9B);
    chk("R3", {40'd0, pa_oe, pb_oe, 6'd0}, 48'd0, "all input");
    chk("R3", {40'd0, pc_oe}, 48'd0, "port C input");
    wreg(3, 8'h80);
    chk("R3", {24'd0, pa_o, pb_o, pc_o}, 48'd0, "latches cleared");
    wreg(3, 8'h8A);
    chk("R3", {38'd0, pa_oe, pb_oe, pc_oe}, {38'd0, 1'b1, 1'b0, 8'h0F}, "mixed directions");
    cur_req = "R5";
    pb_i = 8'hA5;
    rreg(1);
    chk("R5", {40'd0, last_rd}, {40'd0, 8'hA5}, "port B pass-through");

    // R6 group A strobed input
    cur_req = "R6";
    wreg(3, 8'hB0);
    chk("R6", {40'd0, pc_oe}, {40'd0, 8'hEF}, "pin roles");
    wreg(3, 8'h09);
    pa_i = 8'h77; pc_i = 8'hEF; idle();
    chk("R6", {40'd0, pc_o & 8'h28}, {40'd0, 8'h20}, "IBF set, no intr yet");
    pa_i = 8'h11; pc_i = 8'hFF; idle();
    chk("R6", {40'd0, pc_o & 8'h28}, {40'd0, 8'h28}, "intr on strobe rise");
    rreg(0);
    chk("R6", {40'd0, last_rd}, {40'd0, 8'h77}, "latched byte");
    chk("R6", {40'd0, pc_o & 8'h28}, 48'd0, "read clears");
    cur_req = "R10";
    wreg(2, 8'hFF);
    rreg(2);
    chk("R10", {40'd0, last_rd}, {40'd0, 8'hD7}, "port C status read");

    // R7 group A strobed output
    cur_req = "R7";
    wreg(3, 8'hA0);
    wreg(3, 8'h0D);
    wreg(0, 8'h42);
    chk("R7", {40'd0, pc_o & 8'h88}, 48'd0, "OBF low after write");
    pc_i = 8'hBF; idle();
    chk("R7", {40'd0, pc_o & 8'h88}, {40'd0, 8'h88}, "ack clears OBF, sets intr");
    pc_i = 8'hFF; idle();
    wreg(0, 8'h43);
    chk("R7", {40'd0, pc_o & 8'h88}, 48'd0, "write clears intr");

    // R8 group B
    cur_req = "R8";
    wreg(3, 8'h86);
    wreg(3, 8'h05);
    pb_i = 8'hE1; pc_i = 8'hFB; idle();
    chk("R8", {40'd0, pc_o & 8'h03}, {40'd0, 8'h02}, "B input full");
    pb_i = 8'h00; pc_i = 8'hFF; idle();
    chk("R8", {40'd0, pc_o & 8'h03}, {40'd0, 8'h03}, "B intr");
    rreg(1);
    chk("R8", {40'd0, last_rd}, {40'd0, 8'hE1}, "B latched byte");
    chk("R8", {40'd0, pc_o & 8'h03}, 48'd0, "B read clears");
    wreg(3, 8'h84);
    wreg(3, 8'h05);
    wreg(1, 8'h99);
    chk("R8", {40'd0, pc_o & 8'h03}, 48'd0, "B OBF low");
    pc_i = 8'hFB; idle();
    chk("R8", {40'd0, pc_o & 8'h03}, {40'd0, 8'h03}, "B ack");
    pc_i = 8'hFF; idle();

    // R9 bidirectional
    cur_req = "R9";
    wreg(3, 8'hC0);
    wreg(3, 8'h0D);
    wreg(3, 8'h09);
    wreg(0, 8'h5A);
    chk("R9", {39'd0, pa_oe, pc_o[7], 7'd0}, 48'd0, "bus released, OBF low");
    pc_i = 8'hBF; idle();
    chk("R9", {39'd0, pa_oe, pa_o}, {39'd0, 1'b1, 8'h5A}, "drive during ack");
    chk("R9", {40'd0, pc_o & 8'h88}, {40'd0, 8'h88}, "ack: OBF high, intr");
    pc_i = 8'hFF; idle();
    chk("R9", {47'd0, pa_oe}, 48'd0, "released after ack");
    rreg(0);
    chk("R9", {40'd0, pc_o & 8'h08}, 48'd0, "read clears intr");
    pa_i = 8'h3D; pc_i = 8'hEF; idle();
    chk("R9", {40'd0, pc_o & 8'h20}, {40'd0, 8'h20}, "inbound IBF");
    pa_i = 8'h00; pc_i = 8'hFF; idle();
    chk("R9", {40'd0, pc_o & 8'h08}, {40'd0, 8'h08}, "inbound intr");
    rreg(0);
    chk("R9", {40'd0, last_rd}, {40'd0, 8'h3D}, "inbound byte");
    idle();
    finish_run();
  end
endmodule